// File: doc/BRIEF.md
# Timer Interrupt and Wakeup Controller

This block sits beside a general purpose timer and turns its three event strobes (compare match, counter overflow, input capture) into one level-sensitive interrupt request and one wakeup pulse line. Each event has an interrupt-enable bit and an independent wakeup-enable bit. An enabled interrupt event latches a sticky status bit. The interrupt line stays high while any status bit is set.

Software reaches the status, interrupt-enable and wakeup-enable registers through a plain single-cycle register port. A write takes effect on the clock edge where `wr_en` is high. Read data is combinational from `addr`. Status bits are cleared by writing ones. Clearing the capture status bit also sends a one-cycle strobe to the capture unit, which restarts its capture count.

The block carries no data stream. All pins are plain control and status signals, so there is no valid/ready handshake and no back-pressure. Software may issue a register access in every cycle.

Top module: `tmr_evt_ctrl`

## Requirements
- R1: Event vector bit 0 is compare match, bit 1 is overflow and bit 2 is capture. The same positions are used in every register. Register word addresses are 0 for status, 1 for interrupt-enable and 2 for wakeup-enable.
- R2: The interrupt-enable and wakeup-enable registers keep only write data bits 2:0. Higher bits are discarded and read back as zero.
- R3: A status bit becomes set, one cycle after the event strobe, only when its interrupt-enable bit is 1. A masked event leaves status unchanged.
- R4: `irq_o` is high exactly while at least one status bit is set. It falls in the cycle after the write that clears the last set bit.
- R5: Writing 1 to a status bit clears it. Writing 0 leaves that bit unchanged.
- R6: An event whose wakeup-enable bit is 1 produces a `wake_o` pulse exactly one cycle wide, in the cycle after the strobe. This holds whatever the interrupt-enable bit holds.
- R7: A status write with data bit 2 set raises `capt_restart_o` for exactly one cycle, the cycle after the write. A status write with bit 2 clear does not raise it.
- R8: After reset, status, interrupt-enable and wakeup-enable are all zero, and `irq_o`, `wake_o` and `capt_restart_o` are low.
- R9: When an enabled event and a write-one-to-clear hit the same status bit in the same cycle, the event wins and the bit stays set.
- R10: Address 3 is unmapped. It reads as zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 3 | Single-cycle event strobes: match, overflow, capture |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register word address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data, combinational from addr |
| irq_o | output | 1 | Level interrupt request |
| wake_o | output | 1 | One-cycle wakeup pulse |
| capt_restart_o | output | 1 | One-cycle strobe that restarts the capture count |

## Verification
A corrupted status bit shows at the ports one cycle later: `irq_o` rises or stays high with no enabled event behind it, or a status read returns a bit that was never enabled. A wrong wakeup mask bit shows as a missing or extra `wake_o` pulse in the cycle after the strobe. A wrong clear path shows as `irq_o` failing to fall, or falling early, in the cycle after the status write. The race between an event and a clear is driven on purpose, so that a clear-priority bug shows up as a status readback of zero.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;
  parameter int NUM_EVT = 3;
  parameter int REG_DW  = 32;
  parameter int REG_AW  = 2;

  localparam int EVT_MATCH = 0;
  localparam int EVT_OVF   = 1;
  localparam int EVT_CAPT  = 2;

  localparam logic [REG_AW-1:0] ADR_STAT = 2'd0;
  localparam logic [REG_AW-1:0] ADR_IEN  = 2'd1;
  localparam logic [REG_AW-1:0] ADR_WEN  = 2'd2;
endpackage

// File: rtl/tmr_evt_mask.sv
module tmr_evt_mask #(
  parameter int NEVT = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [NEVT-1:0] wdata_i,
  output logic [NEVT-1:0] mask_o
);
  logic [NEVT-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_q <= '0;
    else if (wr_i) mask_q <= wdata_i;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/tmr_evt_status.sv
module tmr_evt_status #(
  parameter int NEVT     = 3,
  parameter int CAPT_BIT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NEVT-1:0] evt_i,
  input  logic [NEVT-1:0] ien_i,
  input  logic [NEVT-1:0] clr_i,
  output logic [NEVT-1:0] status_o,
  output logic            irq_o,
  output logic            restart_o
);
  logic [NEVT-1:0] status_q;
  logic [NEVT-1:0] status_d;
  logic            restart_q;

  // per-bit next state: a set from an enabled event overrides a clear
  for (genvar i = 0; i < NEVT; i++) begin : g_bit
    always_comb begin
      if (evt_i[i] && ien_i[i]) status_d[i] = 1'b1;
      else if (clr_i[i])        status_d[i] = 1'b0;
      else                      status_d[i] = status_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q  <= '0;
      restart_q <= 1'b0;
    end else begin
      status_q  <= status_d;
      restart_q <= clr_i[CAPT_BIT];
    end
  end

  assign status_o  = status_q;
  assign irq_o     = |status_q;
  assign restart_o = restart_q;
endmodule

// File: rtl/tmr_evt_wake.sv
module tmr_evt_wake #(
  parameter int NEVT = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NEVT-1:0] evt_i,
  input  logic [NEVT-1:0] wen_i,
  output logic            wake_o
);
  logic wake_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= |(evt_i & wen_i);
  end

  assign wake_o = wake_q;
endmodule

// File: rtl/tmr_evt_ctrl.sv
module tmr_evt_ctrl
  import tmr_evt_pkg::*;
#(
  parameter int NEVT = NUM_EVT,
  parameter int DW   = REG_DW,
  parameter int AW   = REG_AW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NEVT-1:0] evt_i,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            irq_o,
  output logic            wake_o,
  output logic            capt_restart_o
);
  localparam int PAD_W = DW - NEVT;

  logic [NEVT-1:0] ien_q;
  logic [NEVT-1:0] wen_q;
  logic [NEVT-1:0] status_q;
  logic [NEVT-1:0] clr_vec;
  logic            wr_stat;
  logic            wr_ien;
  logic            wr_wen;

  assign wr_stat = wr_en && (addr == ADR_STAT);
  assign wr_ien  = wr_en && (addr == ADR_IEN);
  assign wr_wen  = wr_en && (addr == ADR_WEN);
  assign clr_vec = wr_stat ? wdata[NEVT-1:0] : '0;

  tmr_evt_mask #(.NEVT(NEVT)) u_ien (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_ien),
    .wdata_i(wdata[NEVT-1:0]), .mask_o(ien_q)
  );

  tmr_evt_mask #(.NEVT(NEVT)) u_wen (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_wen),
    .wdata_i(wdata[NEVT-1:0]), .mask_o(wen_q)
  );

  tmr_evt_status #(.NEVT(NEVT), .CAPT_BIT(EVT_CAPT)) u_stat (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .ien_i(ien_q),
    .clr_i(clr_vec), .status_o(status_q), .irq_o(irq_o),
    .restart_o(capt_restart_o)
  );

  tmr_evt_wake #(.NEVT(NEVT)) u_wake (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wen_i(wen_q),
    .wake_o(wake_o)
  );

  always_comb begin
    case (addr)
      ADR_STAT: rdata = {{PAD_W{1'b0}}, status_q};
      ADR_IEN:  rdata = {{PAD_W{1'b0}}, ien_q};
      ADR_WEN:  rdata = {{PAD_W{1'b0}}, wen_q};
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr_evt_ctrl_chk.sv
module tmr_evt_ctrl_chk #(
  parameter int NEVT = 3,
  parameter int AW   = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NEVT-1:0] evt_i,
  input logic            wr_en,
  input logic [AW-1:0]   addr,
  input logic [NEVT-1:0] wlow,
  input logic            irq_o,
  input logic            wake_o,
  input logic            capt_restart_o,
  input logic [NEVT-1:0] ien_q,
  input logic [NEVT-1:0] wen_q
);
  assert_irq_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(|(evt_i & ien_q)));

  assert_irq_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(wr_en && addr == '0));

  assert_wake_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_i & wen_q)) |=> wake_o);

  assert_wake_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> $past(|(evt_i & wen_q)));

  assert_restart_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    capt_restart_o |-> $past(wr_en && addr == '0 && wlow[NEVT-1]));

  assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_i & ien_q)) |=> irq_o);
endmodule

bind tmr_evt_ctrl tmr_evt_ctrl_chk #(.NEVT(NEVT), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en), .addr(addr),
  .wlow(wdata[NEVT-1:0]), .irq_o(irq_o), .wake_o(wake_o),
  .capt_restart_o(capt_restart_o), .ien_q(ien_q), .wen_q(wen_q)
);

// File: tb/tmr_evt_ctrl_tb.sv
module tmr_evt_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  evt = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, wake, restart;

  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    int          at;
    int          sel;   // 0 irq, 1 wake, 2 restart, 3 rdata
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  tmr_evt_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_o(irq), .wake_o(wake),
    .capt_restart_o(restart)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(int sel, logic [31:0] v, int dly, string tag);
    item_t it;
    int pos;
    it.at = cyc + dly; it.sel = sel; it.exp = v; it.tag = tag;
    pos = q.size();
    for (int i = 0; i < q.size(); i++)
      if (q[i].at > it.at) begin pos = i; break; end
    q.insert(pos, it);
  endtask

  // monitor: pop and compare every item due this cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.sel)
        0: act = {31'b0, irq};
        1: act = {31'b0, wake};
        2: act = {31'b0, restart};
        default: act = rdata;
      endcase
      n_cmp++;
      if (it.at != cyc || act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h (cycle %0d)", it.tag, act, it.exp, cyc);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    tick();
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [1:0] a, logic [31:0] v, string tag);
    addr = a;
    expect_at(3, v, 0, tag);
    tick();
  endtask

  task automatic pulse(logic [2:0] e);
    evt = e;
    tick();
    evt = '0;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R8 reset state
    expect_at(0, 0, 0, "R8 irq");
    expect_at(1, 0, 0, "R8 wake");
    expect_at(2, 0, 0, "R8 restart");
    rd(0, 0, "R8 status");
    rd(1, 0, "R8 ien");
    rd(2, 0, "R8 wen");

    // R2 upper bits discarded
    wr(1, 32'hFFFF_FFFD);
    rd(1, 32'h5, "R2 ien masked");
    wr(2, 32'h0000_00F8);
    rd(2, 32'h0, "R2 wen masked");

    // R3 masked events leave nothing
    wr(1, 0);
    evt = 3'b111; expect_at(0, 0, 1, "R3 masked irq"); expect_at(1, 0, 1, "R6 no wake");
    tick(); evt = '0;
    rd(0, 0, "R3 masked status");

    // R1 bit positions: only match enabled
    wr(1, 32'h1);
    pulse(3'b010);
    rd(0, 0, "R1 overflow masked");
    evt = 3'b001; expect_at(0, 1, 1, "R3 irq set");
    tick(); evt = '0;
    rd(0, 32'h1, "R1 match bit0");

    // R5 zero leaves set bit, R7 restart strobe
    wr_en = 1'b1; addr = 0; wdata = 32'h6;
    expect_at(2, 1, 1, "R7 restart high");
    expect_at(2, 0, 2, "R7 restart one cycle");
    tick(); wr_en = 1'b0;
    rd(0, 32'h1, "R5 zero keeps bit");
    expect_at(0, 1, 0, "R4 irq still high");
    // R4 clear last bit
    wr_en = 1'b1; addr = 0; wdata = 32'h1;
    expect_at(0, 0, 1, "R4 irq falls");
    expect_at(2, 0, 1, "R7 no restart without bit2");
    tick(); wr_en = 1'b0;
    rd(0, 0, "R5 cleared");

    // R6 wake regardless of ien
    wr(1, 0);
    wr(2, 32'h4);
    evt = 3'b100;
    expect_at(1, 1, 1, "R6 wake pulse");
    expect_at(1, 0, 2, "R6 wake one cycle");
    expect_at(0, 0, 1, "R6 no irq");
    tick(); evt = '0;
    tick();
    rd(0, 0, "R6 status clean");

    // R9 event vs clear same cycle
    wr(2, 0);
    wr(1, 32'h7);
    pulse(3'b010);
    wr_en = 1'b1; addr = 0; wdata = 32'h2; evt = 3'b010;
    tick(); wr_en = 1'b0; evt = '0;
    rd(0, 32'h2, "R9 event wins");
    wr_en = 1'b1; addr = 0; wdata = 32'h2; evt = 3'b001;
    tick(); wr_en = 1'b0; evt = '0;
    rd(0, 32'h1, "R9 other bit clears");

    // R4 multiple bits
    pulse(3'b100);
    rd(0, 32'h5, "R1 capture bit2");
    wr_en = 1'b1; addr = 0; wdata = 32'h1;
    expect_at(0, 1, 1, "R4 irq held by bit2");
    tick(); wr_en = 1'b0;
    wr_en = 1'b1; addr = 0; wdata = 32'h4;
    expect_at(0, 0, 1, "R4 irq falls last");
    expect_at(2, 1, 1, "R7 restart on capture clear");
    tick(); wr_en = 1'b0;

    // R10 unmapped address
    wr(3, 32'hFFFF_FFFF);
    rd(3, 0, "R10 unmapped read");
    rd(1, 32'h7, "R10 ien untouched");
    rd(0, 0, "R10 status untouched");

    repeat (4) tick();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: actual %0d pending expected 0", q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule